// File: doc/BRIEF.md
# DMA Controller Register Bank and Interrupt Aggregator

This block is the software-visible face of a multi-channel DMA controller. It decodes a 4 KB window on a simple single-cycle read/write bus and holds five 32-bit words per channel: source address, destination address, linked-list pointer, control and configuration. It also holds a global configuration word. Every channel word is exported in parallel to the transfer engine. The engine itself and its request arbitration live outside this block.

The engine reports completion and failure through per-channel set strobes. Each strobe sets a terminal-count bit or an error bit. Software reads these bits raw or masked and clears them with write-one-to-clear words. The masks are not separate registers: each channel's configuration word carries a terminal-count interrupt enable (bit 15) and an error interrupt enable (bit 14). A single level interrupt output is high while any masked bit is pending.

The build is either eight or two channels, chosen by a parameter. The channel count changes the first identification byte and the range of channel slots that respond.

Top module: `dmac_csr_bank`

## Requirements
- R1: After synchronous reset, every channel word, the global configuration, all terminal-count and error bits, the read data and the interrupt output are zero.
- R2: Channel c word w sits at byte offset 0x100 + 32*c + 4*w: w=0 source, 1 destination, 2 list pointer, 3 control, 4 configuration. Each word reads back the last value written and appears on the matching export port. Words 5 to 7 of a slot read zero.
- R3: Channel slots with an index (offset bits [7:5]) at or above the channel count read zero, and writes to them change no register.
- R4: A one on bit i of the terminal-count or error set strobe sets the matching bit. The raw terminal-count bits read at 0x014 and the raw error bits read at 0x018.
- R5: A channel's configuration bit 15 masks in its terminal-count bit and bit 14 masks in its error bit. Offset 0x004 reads the masked terminal-count bits, 0x00C the masked error bits, and 0x000 their OR.
- R6: A write to 0x008 clears each terminal-count bit whose written bit is 1. A write to 0x010 does the same for the error bits. Zero bits leave their bits unchanged.
- R7: A set strobe and a clearing write hitting the same bit in the same cycle leave the bit set.
- R8: Offset 0x01C reads a bitmap with bit i equal to bit 0 (enable) of channel i's configuration word.
- R9: Offset 0x030 is the global configuration. Only bit 0 is stored, and it drives the global enable output. All other bits read zero.
- R10: Offsets 0xFE0 to 0xFFC return one identification byte per word, in bits [7:0] with the upper bits zero. The sequence is 0x80 (eight channels) or 0x81 (two channels), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R11: All other offsets, including the software request words 0x020 to 0x02C, read zero, and writes to them change nothing.
- R12: The interrupt output is high one cycle after any masked terminal-count or error bit is set, and low one cycle after none is.
- R13: Read data is registered. It takes the addressed value on the cycle after the read strobe and holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (12) | Byte offset in the register window |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| tc_set | input | NCH | Per-channel terminal-count set strobes from the engine |
| err_set | input | NCH | Per-channel error set strobes from the engine |
| ch_src_o | output | NCH*DW | Source address words, channel c at bits [c*DW +: DW] |
| ch_dst_o | output | NCH*DW | Destination address words |
| ch_lli_o | output | NCH*DW | Linked-list pointer words |
| ch_ctrl_o | output | NCH*DW | Control words |
| ch_conf_o | output | NCH*DW | Configuration words |
| dma_en_o | output | 1 | Global enable, bit 0 of the global configuration |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several rules on every cycle. A set strobe always leaves its bit set, and a clear with no matching set always leaves the bit zero. The interrupt only rises when some status bit was pending. Channel words change only when written. Writes to absent slots disturb no export, identification reads never carry upper bits, and read data holds between reads. Some behaviour only the bench scenarios can show. This covers the exact decode of every offset in the window, which is swept completely against a model. It also covers the masks tracking the configuration words, the interrupt falling when bits are cleared or masks removed, and the identification byte values of the two-channel build.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

  typedef enum logic [2:0] {
    CW_SRC  = 3'd0,
    CW_DST  = 3'd1,
    CW_LLI  = 3'd2,
    CW_CTRL = 3'd3,
    CW_CONF = 3'd4
  } chan_word_e;

  localparam logic [5:0] GW_PEND    = 6'd0;
  localparam logic [5:0] GW_TC_MSK  = 6'd1;
  localparam logic [5:0] GW_TC_CLR  = 6'd2;
  localparam logic [5:0] GW_ER_MSK  = 6'd3;
  localparam logic [5:0] GW_ER_CLR  = 6'd4;
  localparam logic [5:0] GW_TC_RAW  = 6'd5;
  localparam logic [5:0] GW_ER_RAW  = 6'd6;
  localparam logic [5:0] GW_EN_MAP  = 6'd7;
  localparam logic [5:0] GW_GCONF   = 6'd12;

  localparam int CONF_EN_BIT   = 0;
  localparam int CONF_ERIE_BIT = 14;
  localparam int CONF_TCIE_BIT = 15;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
    case (idx)
      3'd0:    id_byte = (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dmac_chan_slot.sv
module dmac_chan_slot
  import dmac_csr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] src,
  output logic [DW-1:0] dst,
  output logic [DW-1:0] lli,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] conf
);

  always_ff @(posedge clk) begin
    if (rst) begin
      src  <= '0;
      dst  <= '0;
      lli  <= '0;
      ctrl <= '0;
      conf <= '0;
    end else if (wr_en) begin
      case (chan_word_e'(wsel))
        CW_SRC:  src  <= wdata;
        CW_DST:  dst  <= wdata;
        CW_LLI:  lli  <= wdata;
        CW_CTRL: ctrl <= wdata;
        CW_CONF: conf <= wdata;
        default: ;
      endcase
    end
  end

  // R2: words move only on a write to this slot
  assert_hold_unwritten_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(src) && $stable(dst) && $stable(lli) && $stable(ctrl) && $stable(conf)));

endmodule

// File: rtl/dmac_irq_agg.sv
module dmac_irq_agg #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  input  logic [NCH-1:0] tc_clr,
  input  logic [NCH-1:0] err_clr,
  input  logic [NCH-1:0] tc_mask,
  input  logic [NCH-1:0] err_mask,
  output logic [NCH-1:0] tc_raw,
  output logic [NCH-1:0] err_raw,
  output logic           irq
);

  logic pending;
  assign pending = (|(tc_raw & tc_mask)) | (|(err_raw & err_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_raw  <= '0;
      err_raw <= '0;
      irq     <= 1'b0;
    end else begin
      tc_raw  <= (tc_raw  & ~tc_clr)  | tc_set;
      err_raw <= (err_raw & ~err_clr) | err_set;
      irq     <= pending;
    end
  end

  // R7: a strobe always lands, even against a clear
  assert_set_lands_R7: assert property (@(posedge clk) disable iff (rst)
    (|tc_set || |err_set) |=> (((tc_raw & $past(tc_set)) == $past(tc_set)) &&
                               ((err_raw & $past(err_set)) == $past(err_set))));

  // R6: cleared bits without a competing set read zero next cycle
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (|tc_clr || |err_clr) |=> (((tc_raw & $past(tc_clr & ~tc_set)) == '0) &&
                               ((err_raw & $past(err_clr & ~err_set)) == '0)));

  // R12: the line only rises if some status bit was pending
  assert_irq_source_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|tc_raw || |err_raw));

  // R12: with nothing raw pending the line is low next cycle
  assert_irq_low_R12: assert property (@(posedge clk) disable iff (rst)
    (tc_raw == '0 && err_raw == '0) |=> !irq);

endmodule

// File: rtl/dmac_csr_bank.sv
module dmac_csr_bank
  import dmac_csr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 32,
  parameter int AW  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NCH-1:0]     tc_set,
  input  logic [NCH-1:0]     err_set,
  output logic [NCH*DW-1:0]  ch_src_o,
  output logic [NCH*DW-1:0]  ch_dst_o,
  output logic [NCH*DW-1:0]  ch_lli_o,
  output logic [NCH*DW-1:0]  ch_ctrl_o,
  output logic [NCH*DW-1:0]  ch_conf_o,
  output logic               dma_en_o,
  output logic               irq
);

  localparam int          CIW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [3:0]  NCH_L = 4'(NCH);
  localparam int          IDW   = 8;

  initial assert (NCH == 8 || NCH == 2);

  // address decode
  logic       in_chan, in_glob, in_id, chan_ok;
  logic [2:0] chan_idx, cword;
  logic [5:0] gword;

  assign in_chan  = (bus_addr[11:8] == 4'h1);
  assign in_glob  = (bus_addr[11:8] == 4'h0);
  assign in_id    = (bus_addr[11:5] == 7'h7F);
  assign chan_idx = bus_addr[7:5];
  assign cword    = bus_addr[4:2];
  assign gword    = bus_addr[7:2];
  assign chan_ok  = in_chan && ({1'b0, chan_idx} < NCH_L);

  logic unused_addr_lsb;
  assign unused_addr_lsb = ^bus_addr[1:0];

  // channel slots
  logic [DW-1:0]  src_a [NCH];
  logic [DW-1:0]  dst_a [NCH];
  logic [DW-1:0]  lli_a [NCH];
  logic [DW-1:0]  ctrl_a[NCH];
  logic [DW-1:0]  conf_a[NCH];
  logic [NCH-1:0] tc_mask, err_mask, en_map;

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic slot_wr;
    assign slot_wr = bus_wr && chan_ok && (chan_idx == 3'(c));

    dmac_chan_slot #(.DW(DW)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .wr_en (slot_wr),
      .wsel  (cword),
      .wdata (bus_wdata),
      .src   (src_a[c]),
      .dst   (dst_a[c]),
      .lli   (lli_a[c]),
      .ctrl  (ctrl_a[c]),
      .conf  (conf_a[c])
    );

    assign tc_mask[c]  = conf_a[c][CONF_TCIE_BIT];
    assign err_mask[c] = conf_a[c][CONF_ERIE_BIT];
    assign en_map[c]   = conf_a[c][CONF_EN_BIT];

    assign ch_src_o [c*DW +: DW] = src_a[c];
    assign ch_dst_o [c*DW +: DW] = dst_a[c];
    assign ch_lli_o [c*DW +: DW] = lli_a[c];
    assign ch_ctrl_o[c*DW +: DW] = ctrl_a[c];
    assign ch_conf_o[c*DW +: DW] = conf_a[c];
  end

  // interrupt bits
  logic [NCH-1:0] tc_clr, err_clr, tc_raw, err_raw;
  logic           glob_wr;

  assign glob_wr = bus_wr && in_glob;
  assign tc_clr  = (glob_wr && gword == GW_TC_CLR) ? bus_wdata[NCH-1:0] : '0;
  assign err_clr = (glob_wr && gword == GW_ER_CLR) ? bus_wdata[NCH-1:0] : '0;

  dmac_irq_agg #(.NCH(NCH)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .tc_set   (tc_set),
    .err_set  (err_set),
    .tc_clr   (tc_clr),
    .err_clr  (err_clr),
    .tc_mask  (tc_mask),
    .err_mask (err_mask),
    .tc_raw   (tc_raw),
    .err_raw  (err_raw),
    .irq      (irq)
  );

  // global configuration, enable bit only
  always_ff @(posedge clk) begin
    if (rst)                                dma_en_o <= 1'b0;
    else if (glob_wr && gword == GW_GCONF)  dma_en_o <= bus_wdata[0];
  end

  // read path
  logic [DW-1:0]  rd_next;
  logic [CIW-1:0] sel;
  logic [NCH-1:0] tc_m, er_m;

  assign sel  = chan_idx[CIW-1:0];
  assign tc_m = tc_raw & tc_mask;
  assign er_m = err_raw & err_mask;

  always_comb begin
    rd_next = '0;
    if (in_id) begin
      rd_next = {{(DW-IDW){1'b0}}, id_byte(bus_addr[4:2], NCH)};
    end else if (chan_ok) begin
      case (chan_word_e'(cword))
        CW_SRC:  rd_next = src_a[sel];
        CW_DST:  rd_next = dst_a[sel];
        CW_LLI:  rd_next = lli_a[sel];
        CW_CTRL: rd_next = ctrl_a[sel];
        CW_CONF: rd_next = conf_a[sel];
        default: rd_next = '0;
      endcase
    end else if (in_glob) begin
      case (gword)
        GW_PEND:   rd_next = DW'(tc_m | er_m);
        GW_TC_MSK: rd_next = DW'(tc_m);
        GW_ER_MSK: rd_next = DW'(er_m);
        GW_TC_RAW: rd_next = DW'(tc_raw);
        GW_ER_RAW: rd_next = DW'(err_raw);
        GW_EN_MAP: rd_next = DW'(en_map);
        GW_GCONF:  rd_next = DW'(dma_en_o);
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R13: read data holds between reads
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R10: identification words are byte-wide
  assert_id_byte_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_id) |=> (bus_rdata[DW-1:IDW] == '0));

  // R9: global configuration reads back a single bit
  assert_gconf_width_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_glob && gword == GW_GCONF) |=> (bus_rdata[DW-1:1] == '0));

  // R3: absent slots leave every export untouched
  assert_absent_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_chan && !chan_ok) |=> ($stable(ch_src_o) && $stable(ch_dst_o) &&
      $stable(ch_lli_o) && $stable(ch_ctrl_o) && $stable(ch_conf_o)));

endmodule

// File: tb/sim_dmac_csr_bank.sv
`timescale 1ns/100ps
module sim_dmac_csr_bank;

  localparam int NCH = 2;
  localparam int DW  = 32;
  localparam int AW  = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic [NCH-1:0]    tc_set = '0, err_set = '0;
  logic [NCH*DW-1:0] ch_src_o, ch_dst_o, ch_lli_o, ch_ctrl_o, ch_conf_o;
  logic              dma_en_o, irq;

  always #2.5 clk = ~clk;

  dmac_csr_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc_set(tc_set), .err_set(err_set),
    .ch_src_o(ch_src_o), .ch_dst_o(ch_dst_o), .ch_lli_o(ch_lli_o), .ch_ctrl_o(ch_ctrl_o),
    .ch_conf_o(ch_conf_o), .dma_en_o(dma_en_o), .irq(irq)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0]  m_reg [NCH][5];
  logic [NCH-1:0] m_tc = '0, m_err = '0;
  logic           m_gen = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] m_tcmask();
    for (int c = 0; c < NCH; c++) m_tcmask[c] = m_reg[c][4][15];
  endfunction
  function automatic logic [NCH-1:0] m_ermask();
    for (int c = 0; c < NCH; c++) m_ermask[c] = m_reg[c][4][14];
  endfunction
  function automatic logic [NCH-1:0] m_enmap();
    for (int c = 0; c < NCH; c++) m_enmap[c] = m_reg[c][4][0];
  endfunction

  function automatic logic [DW-1:0] exp_rd(input int a);
    logic [7:0] ids [8];
    int c, w;
    ids = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 'hFE0) return DW'(ids[(a - 'hFE0) >> 2]);
    if (a >= 'h100 && a < 'h200) begin
      c = (a >> 5) & 7; w = (a >> 2) & 7;
      if (c < NCH && w < 5) return m_reg[c][w];
      return '0;
    end
    if (a < 'h100) begin
      case (a >> 2)
        0:  return DW'((m_tc & m_tcmask()) | (m_err & m_ermask()));
        1:  return DW'(m_tc & m_tcmask());
        3:  return DW'(m_err & m_ermask());
        5:  return DW'(m_tc);
        6:  return DW'(m_err);
        7:  return DW'(m_enmap());
        12: return DW'(m_gen);
        default: return '0;
      endcase
    end
    return '0;
  endfunction

  function automatic string tag_of(input int a);
    int c, w;
    if (a >= 'hFE0) return "R10";
    if (a >= 'h100 && a < 'h200) begin
      c = (a >> 5) & 7; w = (a >> 2) & 7;
      if (c >= NCH) return "R3";
      return (w < 5) ? "R2" : "R11";
    end
    if (a < 'h100) begin
      case (a >> 2)
        0, 1, 3: return "R5";
        5, 6:    return "R4";
        7:       return "R8";
        12:      return "R9";
        default: return "R11";
      endcase
    end
    return "R11";
  endfunction

  task automatic m_write(input int a, input logic [DW-1:0] d);
    int c, w;
    if (a >= 'h100 && a < 'h200) begin
      c = (a >> 5) & 7; w = (a >> 2) & 7;
      if (c < NCH && w < 5) m_reg[c][w] = d;
    end else if (a < 'h100) begin
      case (a >> 2)
        2:  m_tc  = m_tc  & ~d[NCH-1:0];
        4:  m_err = m_err & ~d[NCH-1:0];
        12: m_gen = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp_rd(a));
  endtask

  // strobes, optionally with a same-cycle clear write to 0x008
  task automatic strobe(input logic [NCH-1:0] ts, input logic [NCH-1:0] es,
                        input bit clr, input logic [NCH-1:0] cv);
    @(negedge clk);
    tc_set = ts; err_set = es;
    if (clr) begin bus_wr = 1'b1; bus_addr = AW'('h008); bus_wdata = DW'(cv); end
    @(negedge clk);
    tc_set = '0; err_set = '0; bus_wr = 1'b0;
    if (clr) m_tc = m_tc & ~cv;
    m_tc = m_tc | ts; m_err = m_err | es;
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    chk(tag, DW'(irq), DW'(|((m_tc & m_tcmask()) | (m_err & m_ermask()))));
  endtask

  task automatic sweep();
    for (int a = 0; a < 4096; a += 4) rd(a, tag_of(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) for (int w = 0; w < 5; w++) m_reg[c][w] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", DW'(irq), '0);
    chk("R1 rdata", bus_rdata, '0);
    chk("R1 enable", DW'(dma_en_o), '0);
    chk("R1 conf export", ch_conf_o[DW-1:0], '0);
    sweep();

    // R2/R3: write every slot word, present and absent channels
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 8; w++) begin
        logic [DW-1:0] d;
        d = {8'(c), 8'(w), 16'hA5C3 ^ 16'(c * 8 + w)};
        if (w == 4) d = (c == 0) ? 32'h0000_C001 : (c == 1) ? 32'h0000_8000 : 32'hFFFF_FFFF;
        wr('h100 + 32 * c + 4 * w, d);
      end
    chk("R2 src export", ch_src_o[DW +: DW], m_reg[1][0]);
    chk("R2 ctrl export", ch_ctrl_o[DW-1:0], m_reg[0][3]);
    chk("R2 conf export", ch_conf_o[DW-1:0], 32'h0000_C001);

    // R11: undefined and software request words ignore writes
    for (int a = 'h020; a < 'h100; a += 4) if (a != 'h030) wr(a, '1);
    for (int a = 'h200; a < 'h240; a += 4) wr(a, '1);
    for (int a = 'hFE0; a < 'h1000; a += 4) wr(a, '1);
    // R9 global enable
    wr('h030, '1);
    chk("R9 enable port", DW'(dma_en_o), 32'd1);
    sweep();

    // R4/R5/R12 interrupt sequences; ch0 masks both, ch1 masks tc only
    strobe(2'b11, 2'b00, 0, '0);
    chk_irq("R12 tc pending");
    rd('h014, "R4 tc raw"); rd('h004, "R5 tc masked"); rd('h000, "R5 pend");
    strobe(2'b00, 2'b10, 0, '0);
    rd('h018, "R4 err raw"); rd('h00C, "R5 err masked (unmasked ch1)");
    wr('h008, 32'h1);
    chk_irq("R12 ch1 tc still pending");
    rd('h014, "R6 tc clear one bit");
    wr('h008, 32'h2);
    chk_irq("R12 only unmasked error left");
    chk("R12 low", DW'(irq), '0);
    rd('h014, "R6 tc cleared");
    strobe(2'b00, 2'b01, 0, '0);
    chk_irq("R12 err pending");
    rd('h00C, "R5 err masked");
    wr('h010, 32'h1);
    chk_irq("R12 err cleared");
    rd('h018, "R6 err raw after clear");

    // R7: set and clear on the same bit in the same cycle
    strobe(2'b01, 2'b00, 1, 2'b01);
    rd('h014, "R7 set wins");
    chk_irq("R7 irq after set wins");
    // R5/R12: dropping the mask drops the line
    wr('h100 + 16, 32'h0000_0001);
    chk_irq("R12 mask removed");
    chk("R5 irq low with mask off", DW'(irq), '0);
    rd('h000, "R5 pend mask off");
    rd('h01C, "R8 enable map");
    wr('h100 + 32 + 16, 32'h0000_0001);
    rd('h01C, "R8 enable map both");

    // R13: hold with address and strobes moving but no read
    rd('hFE0, "R10 first id");
    @(negedge clk); bus_addr = AW'('h104); tc_set = 2'b10;
    @(negedge clk); tc_set = '0; m_tc = m_tc | 2'b10;
    @(negedge clk);
    chk("R13 hold", bus_rdata, 32'h81);
    wr('h030, '0);
    chk("R9 enable off", DW'(dma_en_o), '0);
    sweep();

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule